// File: doc/BRIEF.md
# Banked Data RAM with Addressing-Mode Routing

This block is the internal data memory of an 8-bit accumulator-style processor core. One access port carries an access kind, an address, a register-bank select, write data and a write enable. From these the block finds the RAM byte or bit being accessed, or hands the access to a separate special-function-register (SFR) port. Storage is 256 bytes by default. One parameter removes the upper half to give a 128-byte variant.

The same address above 0x7F reaches different storage depending on how it is used. A direct byte access there goes out on the SFR port and leaves RAM untouched. An indirect byte access there reaches the upper RAM. The bottom 32 bytes also serve as four banks of eight working registers, chosen by a 2-bit bank input. Bit accesses reach a 16-byte window starting at 0x20, and a bit write changes a single bit in one clock. Decoding instructions and holding SFR contents are left to neighbouring blocks.

Top module: `idm_core`

## Requirements
- R1: The access kind is encoded as 0 = direct byte, 1 = indirect byte, 2 = working register, 3 = single bit. A write with acc_we high takes effect at the rising clock edge. acc_rdata follows the current inputs combinationally in the same cycle.
- R2: Direct and indirect byte accesses at addresses 0x00–0x7F reach the same storage.
- R3: With the upper half enabled, indirect byte accesses at 0x80–0xFF read and write a separate upper 128 bytes of RAM.
- R4: A direct byte access at 0x80 or above never reads or writes RAM. It drives sfr_addr = acc_addr, sfr_wdata = acc_wdata, sfr_we = acc_we and sfr_re = not acc_we, and acc_rdata = sfr_rdata.
- R5: For every access that R4 and R9 do not route to the SFR port, sfr_we, sfr_re, sfr_addr and sfr_wdata are all zero.
- R6: A working-register access to register n = acc_addr[2:0] uses RAM byte acc_bank*8 + n. Address bits 7:3 are ignored.
- R7: A bit access at bit address b below 0x80 reads byte 0x20 + b[6:3], bit b[2:0]. The bit is returned in acc_rdata[0], and acc_rdata[7:1] is zero.
- R8: A bit write sets the addressed bit to acc_wdata[0] in a single clock and leaves the other seven bits of that byte unchanged. acc_wdata[7:1] is ignored.
- R9: A bit access at bit address 0x80 or above is handed to the SFR port with the same signalling as R4 and does not touch RAM.
- R10: With the upper half disabled, an indirect access at 0x80–0xFF reads 0x00 and its write is dropped. No byte of the lower 128 is changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rst_n | input | 1 | Active-low reset (qualifies the checks) |
| acc_kind | input | 2 | Access kind (see R1) |
| acc_addr | input | 8 | Byte, register or bit address |
| acc_bank | input | 2 | Working-register bank select |
| acc_wdata | input | 8 | Write data; bit 0 for bit writes |
| acc_we | input | 1 | Write enable |
| acc_rdata | output | 8 | Read data |
| sfr_addr | output | 8 | SFR address (zero when not selected) |
| sfr_wdata | output | 8 | SFR write data (zero when not selected) |
| sfr_we | output | 1 | SFR write strobe |
| sfr_re | output | 1 | SFR read strobe |
| sfr_rdata | input | 8 | SFR read return |

## Verification
Read data and every SFR-port output depend only on the current inputs and stored contents, so they are due in the same cycle as the stimulus. The bench drives each access on the falling edge and samples one time unit later, well before the next rising edge. A write lands at that rising edge, so any read-back is sampled one cycle after the write was presented. A full and a 128-byte instance run side by side against two arithmetic byte models. The sweeps cover every byte address in both modes, every bank and register, and every bit address.

// File: rtl/idm_pkg.sv
package idm_pkg;
   typedef enum logic [1:0] {
      ACC_DIRECT   = 2'd0,
      ACC_INDIRECT = 2'd1,
      ACC_WREG     = 2'd2,
      ACC_BIT      = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/idm_route.sv
module idm_route
   import idm_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int BANK_W   = 2,
   parameter int IDX_W    = 8,
   parameter bit UPPER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BANK_W-1:0] bank,
   output logic              sfr_sel,
   output logic              void_sel,
   output logic              ram_sel,
   output logic              bit_mode,
   output logic [2:0]        bit_pos,
   output logic [IDX_W-1:0]  ram_idx
);
   localparam int REG_BITS = 3;
   localparam int WIN_BITS = ADDR_W - 1 - REG_BITS;
   localparam logic [ADDR_W-1:0] BIT_BASE = ADDR_W'(8'h20);

   acc_kind_e k;
   logic      hi;
   logic [ADDR_W-1:0] idx_full;

   assign k  = acc_kind_e'(kind);
   assign hi = addr[ADDR_W-1];

   always_comb begin
      sfr_sel  = 1'b0;
      void_sel = 1'b0;
      bit_mode = 1'b0;
      bit_pos  = addr[2:0];
      idx_full = addr;
      unique case (k)
         ACC_DIRECT:   sfr_sel  = hi;
         ACC_INDIRECT: void_sel = hi && !UPPER_EN;
         ACC_WREG:     idx_full = ADDR_W'({bank, addr[REG_BITS-1:0]});
         ACC_BIT: begin
            sfr_sel  = hi;
            bit_mode = !hi;
            idx_full = BIT_BASE + ADDR_W'(addr[ADDR_W-2:REG_BITS]);
         end
         default: ;
      endcase
   end

   assign ram_sel = !sfr_sel && !void_sel;
   assign ram_idx = IDX_W'(idx_full);

   // R4
   direct_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 2'd0 && addr[ADDR_W-1]) |-> (sfr_sel && !ram_sel));

   initial begin
      if (WIN_BITS != 4) $error("bit window needs an 8-bit address");
   end
endmodule

// File: rtl/idm_store.sv
module idm_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 256,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              bit_mode,
   input  logic [2:0]        bit_pos,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] nxt;

   assign rdata = mem[idx];

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_lane
      always_comb begin
         if (!bit_mode)                  nxt[gi] = wdata[gi];
         else if (bit_pos == 3'(gi))     nxt[gi] = wdata[0];
         else                            nxt[gi] = rdata[gi];
      end
   end

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= nxt;
   end

   logic              chk_vld;
   logic [IDX_W-1:0]  chk_idx;
   logic [DATA_W-1:0] chk_old;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_vld <= 1'b0;
         chk_idx <= '0;
         chk_old <= '0;
      end else begin
         chk_vld <= we && bit_mode;
         chk_idx <= idx;
         chk_old <= rdata;
      end
   end

   // R8
   bit_rmw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld |-> $onehot0(mem[chk_idx] ^ chk_old));
endmodule

// File: rtl/idm_core.sv
module idm_core
   import idm_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 8,
   parameter int BANK_W   = 2,
   parameter bit UPPER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        acc_kind,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [BANK_W-1:0] acc_bank,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_we,
   output logic [DATA_W-1:0] acc_rdata,
   output logic [ADDR_W-1:0] sfr_addr,
   output logic [DATA_W-1:0] sfr_wdata,
   output logic              sfr_we,
   output logic              sfr_re,
   input  logic [DATA_W-1:0] sfr_rdata
);
   localparam int DEPTH = UPPER_EN ? (1 << ADDR_W) : (1 << (ADDR_W - 1));
   localparam int IDX_W = $clog2(DEPTH);

   if (DATA_W != 8) begin : g_bad_data
      $error("data width must be 8");
   end
   if (ADDR_W != 8) begin : g_bad_addr
      $error("address width must be 8");
   end
   if (BANK_W != 2) begin : g_bad_bank
      $error("bank select must be 2 bits");
   end

   logic             sfr_sel, void_sel, ram_sel, bit_mode;
   logic [2:0]       bit_pos;
   logic [IDX_W-1:0] ram_idx;
   logic [DATA_W-1:0] ram_rd;

   idm_route #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .IDX_W(IDX_W), .UPPER_EN(UPPER_EN)
   ) u_route (
      .clk(clk), .rst_n(rst_n), .kind(acc_kind), .addr(acc_addr),
      .bank(acc_bank), .sfr_sel(sfr_sel), .void_sel(void_sel),
      .ram_sel(ram_sel), .bit_mode(bit_mode), .bit_pos(bit_pos),
      .ram_idx(ram_idx)
   );

   idm_store #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .we(acc_we && ram_sel), .bit_mode(bit_mode),
      .bit_pos(bit_pos), .idx(ram_idx), .wdata(acc_wdata), .rdata(ram_rd)
   );

   assign sfr_addr  = sfr_sel ? acc_addr  : '0;
   assign sfr_wdata = sfr_sel ? acc_wdata : '0;
   assign sfr_we    = sfr_sel &&  acc_we;
   assign sfr_re    = sfr_sel && !acc_we;

   always_comb begin
      if (sfr_sel)       acc_rdata = sfr_rdata;
      else if (void_sel) acc_rdata = '0;
      else if (bit_mode) acc_rdata = DATA_W'(ram_rd[bit_pos]);
      else               acc_rdata = ram_rd;
   end

   // R5
   sfr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == 2'd1 || acc_kind == 2'd2 || !acc_addr[ADDR_W-1])
      |-> (!sfr_we && !sfr_re && sfr_addr == '0 && sfr_wdata == '0));

   // R7
   bit_read_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == 2'd3 && !acc_addr[ADDR_W-1]) |-> (acc_rdata[DATA_W-1:1] == '0));

   // R10
   void_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!UPPER_EN && acc_kind == 2'd1 && acc_addr[ADDR_W-1]) |-> (acc_rdata == '0));
endmodule

// File: tb/idm_core_test.sv
module idm_core_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] kind = 2'd0;
   logic [7:0] addr = 8'h00;
   logic [1:0] bank = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic       we = 1'b0;
   logic [7:0] rd_f, rd_s, sa_f, sw_f, sa_s, sw_s, sr_f, sr_s;
   logic       swe_f, sre_f, swe_s, sre_s;

   int vectors = 0;
   int misses = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign sr_f = ~sa_f;
   assign sr_s = ~sa_s;

   idm_core #(.UPPER_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .acc_kind(kind), .acc_addr(addr),
      .acc_bank(bank), .acc_wdata(wdata), .acc_we(we), .acc_rdata(rd_f),
      .sfr_addr(sa_f), .sfr_wdata(sw_f), .sfr_we(swe_f), .sfr_re(sre_f),
      .sfr_rdata(sr_f)
   );

   idm_core #(.UPPER_EN(1'b0)) uut_small (
      .clk(clk), .rst_n(rst_n), .acc_kind(kind), .acc_addr(addr),
      .acc_bank(bank), .acc_wdata(wdata), .acc_we(we), .acc_rdata(rd_s),
      .sfr_addr(sa_s), .sfr_wdata(sw_s), .sfr_we(swe_s), .sfr_re(sre_s),
      .sfr_rdata(sr_s)
   );

   logic [7:0] mf [256];
   logic [7:0] ms [128];

   function automatic logic [7:0] mget(bit up, logic [7:0] a);
      return up ? mf[a] : ms[a[6:0]];
   endfunction

   function automatic logic [7:0] exp_rd(bit up);
      logic [7:0] by;
      case (kind)
         2'd0: return addr[7] ? ~addr : mget(up, addr);
         2'd1: return (addr[7] && !up) ? 8'h00 : mget(up, addr);
         2'd2: return mget(up, {3'b000, bank, addr[2:0]});
         default: begin
            if (addr[7]) return ~addr;
            by = mget(up, 8'h20 + {4'h0, addr[6:3]});
            return {7'b0, by[addr[2:0]]};
         end
      endcase
   endfunction

   function automatic void mput(bit up, logic [7:0] a, logic [7:0] d);
      if (up) mf[a] = d;
      else ms[a[6:0]] = d;
   endfunction

   function automatic void model_write(bit up);
      logic [7:0] t;
      case (kind)
         2'd0: if (!addr[7]) mput(up, addr, wdata);
         2'd1: if (!addr[7] || up) mput(up, addr, wdata);
         2'd2: mput(up, {3'b000, bank, addr[2:0]}, wdata);
         default: if (!addr[7]) begin
            t = mget(up, 8'h20 + {4'h0, addr[6:3]});
            t[addr[2:0]] = wdata[0];
            mput(up, 8'h20 + {4'h0, addr[6:3]}, t);
         end
      endcase
   endfunction

   task automatic check(string req, string what, logic [17:0] act, logic [17:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic acc(string req, logic [1:0] k, logic [7:0] a, logic [1:0] b,
                      logic [7:0] d, logic w, bit chk_rd);
      bit sel;
      @(negedge clk);
      kind = k; addr = a; bank = b; wdata = d; we = w;
      #1;
      sel = (k == 2'd0 || k == 2'd3) && a[7];
      if (chk_rd) begin
         check(req, "rdata full",  {10'b0, rd_f}, {10'b0, exp_rd(1'b1)});
         check(req, "rdata small", {10'b0, rd_s}, {10'b0, exp_rd(1'b0)});
      end
      check(req, "sfr port", {sa_f, sw_f, swe_f, sre_f},
            sel ? {a, d, w, ~w} : 18'h0);
      check(req, "sfr port small", {sa_s, sw_s, swe_s, sre_s},
            sel ? {a, d, w, ~w} : 18'h0);
      if (w) begin
         model_write(1'b1);
         model_write(1'b0);
      end
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            misses++;
            vectors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R5 at reset: idle low-address access leaves the SFR port quiet
      check("R5", "sfr at reset", {sa_f, sw_f, swe_f, sre_f}, 18'h0);
      rst_n = 1'b1;

      // R2: fill lower half directly
      for (int a = 0; a < 128; a++) acc("R2", 2'd0, 8'(a), 2'd0, 8'(a * 7 + 3), 1'b1, 1'b0);
      // R3 / R10: fill upper half indirectly
      for (int a = 128; a < 256; a++) acc("R3", 2'd1, 8'(a), 2'd0, 8'(a) ^ 8'h5A, 1'b1, 1'b0);
      // R2: same bytes seen indirectly
      for (int a = 0; a < 128; a++) acc("R2", 2'd1, 8'(a), 2'd0, 8'h00, 1'b0, 1'b1);
      // R3 and R10: upper half (small reads zero)
      for (int a = 128; a < 256; a++) acc("R3", 2'd1, 8'(a), 2'd0, 8'h00, 1'b0, 1'b1);
      // R4: direct high addresses go to SFR, RAM untouched
      for (int a = 128; a < 256; a++) begin
         acc("R4", 2'd0, 8'(a), 2'd0, 8'h00, 1'b0, 1'b1);
         acc("R4", 2'd0, 8'(a), 2'd0, ~8'(a), 1'b1, 1'b1);
         acc("R4", 2'd1, 8'(a), 2'd0, 8'h00, 1'b0, 1'b1);
      end
      // R10: dropped upper writes never aliased onto lower bytes
      for (int a = 0; a < 128; a++) acc("R10", 2'd0, 8'(a), 2'd0, 8'h00, 1'b0, 1'b1);
      // R1: write then read the next cycle
      acc("R1", 2'd1, 8'h44, 2'd0, 8'hC3, 1'b1, 1'b1);
      acc("R1", 2'd0, 8'h44, 2'd0, 8'h00, 1'b0, 1'b1);
      // R6: banked registers, upper address bits ignored
      for (int b = 0; b < 4; b++)
         for (int n = 0; n < 8; n++) begin
            acc("R6", 2'd2, {5'b10101, 3'(n)}, 2'(b), 8'(b * 37 + n * 5 + 1), 1'b1, 1'b1);
            acc("R6", 2'd0, 8'(b * 8 + n), 2'd0, 8'h00, 1'b0, 1'b1);
            acc("R6", 2'd2, {5'b01010, 3'(n)}, 2'(b), 8'h00, 1'b0, 1'b1);
         end
      // R7, R8: every bit of the window, upper wdata bits set to show they are ignored
      for (int b = 0; b < 128; b++) begin
         logic v;
         v = 1'(b) ^ 1'(b >> 4);
         acc("R8", 2'd3, 8'(b), 2'd0, {7'h7F, v}, 1'b1, 1'b1);
         acc("R7", 2'd3, 8'(b), 2'd0, 8'h00, 1'b0, 1'b1);
         acc("R8", 2'd0, 8'h20 + 8'(b >> 3), 2'd0, 8'h00, 1'b0, 1'b1);
      end
      // R9: high bit addresses forwarded to SFR
      for (int b = 128; b < 256; b += 3) begin
         acc("R9", 2'd3, 8'(b), 2'd0, 8'h00, 1'b0, 1'b1);
         acc("R9", 2'd3, 8'(b), 2'd0, 8'h01, 1'b1, 1'b1);
      end
      // R9: window bytes unchanged by forwarded bit writes
      for (int a = 32; a < 48; a++) acc("R9", 2'd0, 8'(a), 2'd0, 8'h00, 1'b0, 1'b1);

      @(negedge clk);
      we = 1'b0;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule